// File: doc/BRIEF.md
# Address-less Asynchronous Bus Burst Reader

This block is the host side of a narrow asynchronous parallel bus that talks to a peripheral behaving like a FIFO. The peripheral has no address pins. Every read goes to the same location, and the peripheral hands out its next word each time output enable falls. No clock is sent across the bus. The block times each read with its own clock, using programmable cycle counts: it drives an active-low chip select and an active-low output enable, and it samples the data bus in a programmed cycle.

A start pulse launches a burst. The block repeats single-word reads until a fixed byte count has been moved. Each captured word goes out on a one-cycle write strobe with a destination index that begins at zero and steps by one word per read. When the last read ends, the block drops busy and raises a done flag. The done flag stays up until the next accepted start.

Software-visible timing comes in on plain input pins. The block copies those pins into internal registers when a burst is accepted. An optional idle cycle with chip select released can be placed between consecutive reads.

Top module: `fifo_bus_burst_reader`

## Requirements
- R1: While reset is asserted and right after it, bus_cs_n and bus_oe_n are 1, and wr_en, busy and done are 0.
- R2: Within a burst, bus_cs_n is low for exactly cfg_cs_off cycles per read, counted from cycle 0 of that read. It is high whenever busy is 0.
- R3: In a read, bus_oe_n is low in exactly the cycles whose position p (0 = first chip-select cycle) satisfies cfg_oe_on <= p < cfg_oe_off. It is never low while bus_cs_n is high.
- R4: The word on bus_data during read cycle p = cfg_sample is presented on wr_data with wr_en high for one cycle, in the following cycle.
- R5: wr_idx is 0 for the first write of a burst and increases by one for each later write. The bus side carries no address, so every read targets the same location.
- R6: With cfg_gap = 1, exactly one cycle with bus_cs_n high separates consecutive reads, and none follows the last. A burst keeps busy high for WORDS*cfg_cs_off + (WORDS-1)*cfg_gap cycles, where WORDS = BURST_BYTES/2.
- R7: At the clock edge that ends the last read, busy falls and done rises. done stays 1 until the next accepted start clears it at the edge that sets busy.
- R8: A start pulse while busy is 1 is ignored. The burst still produces exactly WORDS writes, with indices 0 to WORDS-1, and its length does not change.
- R9: The timing inputs are captured when a start is accepted. Changing them while busy has no effect on the running burst.
- R10: One burst moves BURST_BYTES bytes, which is BURST_BYTES/2 reads of 16-bit words and BURST_BYTES/2 write strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock (125 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst launch pulse, accepted only while idle |
| cfg_cs_off | input | TIME_W | Read length: cycle at which chip select releases |
| cfg_oe_on | input | TIME_W | Cycle at which output enable asserts |
| cfg_oe_off | input | TIME_W | Cycle at which output enable releases |
| cfg_sample | input | TIME_W | Cycle in which bus_data is captured |
| cfg_gap | input | 1 | Insert one idle cycle between reads |
| bus_data | input | DATA_W | Peripheral data bus |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_oe_n | output | 1 | Active-low output enable |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | IDX_W | Destination word index |
| wr_data | output | DATA_W | Destination write data |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Burst completed, held until next start |

## Verification
The bench builds the block with BURST_BYTES = 16, which gives an 8-word burst, TIME_W = 5 and GAP_EN = 1. The short burst brings the final read, the falling busy, the held done flag, and a late start landing mid-burst into reach within a few hundred cycles per case. TIME_W = 5 still fits the nominal 16-cycle read with output enable from 3 to 16 and capture in cycle 15. It also admits the extremes: a two-cycle read, and capture in the very last chip-select cycle, where the write strobe appears after busy has already fallen.

// File: rtl/abr_pkg.sv
package abr_pkg;

   localparam int unsigned TF_W = 8;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_ACCESS = 2'd1,
      PH_GAP    = 2'd2
   } phase_e;

   typedef struct packed {
      logic [TF_W-1:0] cs_off;
      logic [TF_W-1:0] oe_on;
      logic [TF_W-1:0] oe_off;
      logic [TF_W-1:0] sample;
      logic            gap;
   } rd_timing_t;

   function automatic logic in_window(input logic [TF_W-1:0] pos,
                                      input logic [TF_W-1:0] lo,
                                      input logic [TF_W-1:0] hi);
      return (pos >= lo) && (pos < hi);
   endfunction

endpackage

// File: rtl/abr_cfg_hold.sv
module abr_cfg_hold
   import abr_pkg::*;
#(
   parameter bit GAP_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  rd_timing_t cfg_in,
   output rd_timing_t cfg_q
);

   rd_timing_t held;
   logic       gap_src;

   generate
      if (GAP_EN) begin : g_gap
         assign gap_src = cfg_in.gap;
      end else begin : g_nogap
         assign gap_src = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held.cs_off <= TF_W'(1);
         held.oe_on  <= '0;
         held.oe_off <= TF_W'(1);
         held.sample <= '0;
         held.gap    <= 1'b0;
      end else if (load) begin
         held.cs_off <= cfg_in.cs_off;
         held.oe_on  <= cfg_in.oe_on;
         held.oe_off <= cfg_in.oe_off;
         held.sample <= cfg_in.sample;
         held.gap    <= gap_src;
      end
   end

   assign cfg_q = held;

endmodule

// File: rtl/abr_access_seq.sv
module abr_access_seq
   import abr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  rd_timing_t cfg,
   input  logic       last_word,
   output logic       cs_n,
   output logic       oe_n,
   output logic       capture,
   output logic       acc_end
);

   phase_e          phase;
   logic [TF_W-1:0] cyc;
   logic            in_access;

   assign in_access = (phase == PH_ACCESS);
   assign acc_end   = in_access && (cyc == cfg.cs_off - TF_W'(1));
   assign capture   = in_access && (cyc == cfg.sample);
   assign cs_n      = !in_access;
   assign oe_n      = !(in_access && in_window(cyc, cfg.oe_on, cfg.oe_off));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cyc   <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (go) begin
                  phase <= PH_ACCESS;
                  cyc   <= '0;
               end
            end
            PH_ACCESS: begin
               if (acc_end) begin
                  cyc <= '0;
                  if (last_word) begin
                     phase <= PH_IDLE;
                  end else if (cfg.gap) begin
                     phase <= PH_GAP;
                  end
               end else begin
                  cyc <= cyc + TF_W'(1);
               end
            end
            PH_GAP: begin
               phase <= PH_ACCESS;
            end
            default: begin
               phase <= PH_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/abr_burst_ctrl.sv
module abr_burst_ctrl #(
   parameter int unsigned WORDS  = 4096,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned IDX_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              acc_end,
   input  logic              capture,
   input  logic [DATA_W-1:0] bus_data,
   output logic              go,
   output logic              last_word,
   output logic              busy,
   output logic              done,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data
);

   logic [IDX_W-1:0] word_cnt;

   assign go        = start && !busy;
   assign last_word = (word_cnt == IDX_W'(WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         word_cnt <= '0;
      end else if (go) begin
         busy     <= 1'b1;
         done     <= 1'b0;
         word_cnt <= '0;
      end else if (acc_end) begin
         if (last_word) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            word_cnt <= word_cnt + IDX_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= capture;
         if (capture) begin
            wr_idx  <= word_cnt;
            wr_data <= bus_data;
         end
      end
   end

endmodule

// File: rtl/fifo_bus_burst_reader.sv
module fifo_bus_burst_reader
   import abr_pkg::*;
#(
   parameter int unsigned BURST_BYTES = 8192,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned TIME_W      = 5,
   parameter bit          GAP_EN      = 1'b1,
   localparam int unsigned WORDS      = BURST_BYTES / 2,
   localparam int unsigned IDX_W      = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [TIME_W-1:0] cfg_cs_off,
   input  logic [TIME_W-1:0] cfg_oe_on,
   input  logic [TIME_W-1:0] cfg_oe_off,
   input  logic [TIME_W-1:0] cfg_sample,
   input  logic              cfg_gap,
   input  logic [DATA_W-1:0] bus_data,
   output logic              bus_cs_n,
   output logic              bus_oe_n,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              done
);

   generate
      if (BURST_BYTES < 4 || (BURST_BYTES % 2) != 0) begin : g_bad_bytes
         $error("BURST_BYTES must be even and at least 4");
      end
      if (TIME_W < 2 || TIME_W > TF_W) begin : g_bad_time
         $error("TIME_W out of supported range");
      end
      if (DATA_W != 16) begin : g_bad_data
         $error("word size must be 16 bits for byte-count conversion");
      end
   endgenerate

   rd_timing_t cfg_in;
   rd_timing_t cfg_q;
   logic       go;
   logic       last_word;
   logic       capture;
   logic       acc_end;

   assign cfg_in.cs_off = TF_W'(cfg_cs_off);
   assign cfg_in.oe_on  = TF_W'(cfg_oe_on);
   assign cfg_in.oe_off = TF_W'(cfg_oe_off);
   assign cfg_in.sample = TF_W'(cfg_sample);
   assign cfg_in.gap    = cfg_gap;

   abr_cfg_hold #(
      .GAP_EN (GAP_EN)
   ) cfg_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (go),
      .cfg_in (cfg_in),
      .cfg_q  (cfg_q)
   );

   abr_access_seq seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .cfg       (cfg_q),
      .last_word (last_word),
      .cs_n      (bus_cs_n),
      .oe_n      (bus_oe_n),
      .capture   (capture),
      .acc_end   (acc_end)
   );

   abr_burst_ctrl #(
      .WORDS  (WORDS),
      .DATA_W (DATA_W)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .acc_end   (acc_end),
      .capture   (capture),
      .bus_data  (bus_data),
      .go        (go),
      .last_word (last_word),
      .busy      (busy),
      .done      (done),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data)
   );

endmodule

// File: rtl/abr_checker.sv
module abr_checker #(
   parameter int unsigned IDX_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             bus_cs_n,
   input logic             bus_oe_n,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_idx,
   input logic             busy,
   input logic             done
);

   logic [IDX_W-1:0] exp_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_idx <= '0;
      end else if (start && !busy) begin
         exp_idx <= '0;
      end else if (wr_en) begin
         exp_idx <= exp_idx + IDX_W'(1);
      end
   end

   // R2
   a_r2_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> bus_cs_n);

   // R3
   a_r3_oe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe_n |-> !bus_cs_n);

   // R4
   a_r4_capture_under_oe: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(!bus_oe_n));

   // R5
   a_r5_index_order: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx == exp_idx));

   // R7
   a_r7_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r7_done_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));

   // R8
   a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));

endmodule

bind fifo_bus_burst_reader abr_checker #(
   .IDX_W (IDX_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .bus_cs_n (bus_cs_n),
   .bus_oe_n (bus_oe_n),
   .wr_en    (wr_en),
   .wr_idx   (wr_idx),
   .busy     (busy),
   .done     (done)
);

// File: tb/fifo_bus_burst_reader_tb_top.sv
module fifo_bus_burst_reader_tb_top;

   localparam int BYTES  = 16;
   localparam int N      = BYTES / 2;
   localparam int TW     = 5;
   localparam int IW     = $clog2(N);
   localparam int LIMIT  = 2000;

   typedef struct packed {
      logic [7:0]  cs_off;
      logic [7:0]  oe_on;
      logic [7:0]  oe_off;
      logic [7:0]  smp;
      logic        gap;
      logic [15:0] seed;
   } vec_t;

   localparam int NV = 4;
   localparam vec_t VEC [NV] = '{
      '{8'd16, 8'd3, 8'd16, 8'd15, 1'b0, 16'h0000},
      '{8'd16, 8'd3, 8'd16, 8'd15, 1'b1, 16'h1000},
      '{8'd2,  8'd0, 8'd2,  8'd1,  1'b1, 16'hFFFA},
      '{8'd5,  8'd1, 8'd5,  8'd4,  1'b0, 16'h2222}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [TW-1:0] cfg_cs_off = '0;
   logic [TW-1:0] cfg_oe_on = '0;
   logic [TW-1:0] cfg_oe_off = '0;
   logic [TW-1:0] cfg_sample = '0;
   logic          cfg_gap = 1'b0;
   logic [15:0]   bus_data;
   logic          bus_cs_n, bus_oe_n, wr_en, busy, done;
   logic [IW-1:0] wr_idx;
   logic [15:0]   wr_data;

   logic [15:0]   pops = '0;
   logic [15:0]   base = '0;
   logic [15:0]   seed = '0;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   int m_busy, m_cs, m_gapc, m_wr, m_oe_bad, m_data_bad, m_idx_bad, m_done_first, m_timeout;

   always #4 clk = ~clk;

   always @(negedge bus_oe_n) pops <= pops + 16'd1;
   assign bus_data = seed + (pops - base);

   fifo_bus_burst_reader #(
      .BURST_BYTES (BYTES),
      .DATA_W      (16),
      .TIME_W      (TW),
      .GAP_EN      (1'b1)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cfg_cs_off (cfg_cs_off),
      .cfg_oe_on  (cfg_oe_on),
      .cfg_oe_off (cfg_oe_off),
      .cfg_sample (cfg_sample),
      .cfg_gap    (cfg_gap),
      .bus_data   (bus_data),
      .bus_cs_n   (bus_cs_n),
      .bus_oe_n   (bus_oe_n),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .busy       (busy),
      .done       (done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic apply_cfg(input vec_t v);
      cfg_cs_off = TW'(v.cs_off);
      cfg_oe_on  = TW'(v.oe_on);
      cfg_oe_off = TW'(v.oe_off);
      cfg_sample = TW'(v.smp);
      cfg_gap    = v.gap;
   endtask

   // Launch a burst from a negedge and observe it until done has been seen twice.
   task automatic run_burst(input vec_t v, input int restart_at, input int mess_at);
      int pos;
      int done_seen;
      bit oe_exp;
      pos = 0;
      done_seen = 0;
      m_busy = 0; m_cs = 0; m_gapc = 0; m_wr = 0;
      m_oe_bad = 0; m_data_bad = 0; m_idx_bad = 0; m_timeout = 1;
      m_done_first = -1;
      apply_cfg(v);
      seed  = v.seed;
      base  = pops;
      start = 1'b1;
      for (int c = 0; c < LIMIT; c++) begin
         @(negedge clk);
         if (c == 0) m_done_first = int'(done);
         if (busy) m_busy++;
         if (busy && bus_cs_n) m_gapc++;
         if (!bus_cs_n) begin
            m_cs++;
            oe_exp = (pos >= int'(v.oe_on)) && (pos < int'(v.oe_off));
            if (oe_exp != !bus_oe_n) m_oe_bad++;
            pos = (pos + 1 == int'(v.cs_off)) ? 0 : pos + 1;
         end else if (!bus_oe_n) begin
            m_oe_bad++;
         end
         if (wr_en) begin
            if (int'(wr_idx) != m_wr) m_idx_bad++;
            if (wr_data != 16'(seed + 16'(m_wr) + 16'd1)) m_data_bad++;
            m_wr++;
         end
         start = (c == restart_at);
         if (c == mess_at) begin
            cfg_cs_off = TW'(3);
            cfg_oe_on  = TW'(0);
            cfg_oe_off = TW'(3);
            cfg_sample = TW'(1);
            cfg_gap    = ~v.gap;
         end
         if (done && !busy) done_seen++;
         if (done_seen == 2) begin
            m_timeout = 0;
            break;
         end
      end
      start = 1'b0;
   endtask

   task automatic check_burst(input vec_t v, input string tag);
      int exp_busy;
      exp_busy = N * int'(v.cs_off) + (N - 1) * int'(v.gap);
      check(m_timeout == 0, "R7", {tag, " completion seen"}, m_timeout, 0);
      check(m_done_first == 0, "R7", {tag, " done cleared by start"}, m_done_first, 0);
      check(m_cs == N * int'(v.cs_off), "R2", {tag, " cs low cycles"}, m_cs, N * int'(v.cs_off));
      check(m_oe_bad == 0, "R3", {tag, " oe window errors"}, m_oe_bad, 0);
      check(m_data_bad == 0, "R4", {tag, " captured data errors"}, m_data_bad, 0);
      check(m_idx_bad == 0, "R5", {tag, " index errors"}, m_idx_bad, 0);
      check(m_busy == exp_busy, "R6", {tag, " busy cycles"}, m_busy, exp_busy);
      check(m_gapc == (N - 1) * int'(v.gap), "R6", {tag, " gap cycles"}, m_gapc, (N - 1) * int'(v.gap));
      check(m_wr == N, "R10", {tag, " write strobes"}, m_wr, N);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual expired expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      check(bus_cs_n && bus_oe_n && !wr_en && !busy && !done, "R1", "idle during reset",
            {bus_cs_n, bus_oe_n, wr_en, busy, done}, 5'b11000);
      rst_n = 1'b1;
      @(negedge clk);
      check(bus_cs_n && bus_oe_n && !wr_en && !busy && !done, "R1", "idle after reset",
            {bus_cs_n, bus_oe_n, wr_en, busy, done}, 5'b11000);

      // Table walk: R2..R7, R10 under several timings
      for (int i = 0; i < NV; i++) begin
         run_burst(VEC[i], -1, -1);
         check_burst(VEC[i], $sformatf("vec%0d", i));
      end

      // R7: done holds and bus stays released
      repeat (6) @(negedge clk);
      check(done == 1'b1, "R7", "done held while idle", int'(done), 1);
      check(bus_cs_n == 1'b1 && busy == 1'b0, "R2", "bus released after burst",
            int'(bus_cs_n), 1);

      // R8: start while busy ignored
      run_burst(VEC[1], 3, -1);
      check_burst(VEC[1], "R8 restart");

      // R9: config changes during burst have no effect
      run_burst(VEC[0], -1, 2);
      check_burst(VEC[0], "R9 cfg change");

      // R1: reset in the middle of a burst
      apply_cfg(VEC[0]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      check(busy == 1'b1, "R8", "burst running before reset", int'(busy), 1);
      rst_n = 1'b0;
      @(negedge clk);
      check(bus_cs_n && bus_oe_n && !wr_en && !busy && !done, "R1", "mid-burst reset",
            {bus_cs_n, bus_oe_n, wr_en, busy, done}, 5'b11000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(bus_cs_n == 1'b1, "R1", "stays idle after reset", int'(bus_cs_n), 1);

      finish_run();
   end

endmodule